// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block owns the 16-bit program counter of an 8-bit accumulator-style microcontroller and sequences its unconditional control transfers. Instruction bytes arrive one per cycle over a byte-wide fetch interface: the block shows the address it wants next on `pc_o` and takes the byte on `fetch_byte_i` in any cycle where `fetch_valid_i` is high. Multi-byte instructions are collected across cycles. The new PC is applied in the cycle that takes the last byte.

It resolves seven kinds of target. A short jump adds a signed offset. Long jumps and long calls load a full 16-bit address. Page jumps and page calls replace the low eleven bits inside the current 2K block. The indexed jump adds the accumulator to the data pointer. Return and return-from-interrupt pop the PC from an internal byte stack. Each call pushes its return address onto that stack, and the stack is addressed by an 8-bit stack pointer. An interrupt-in-progress flag is set from outside and cleared by return-from-interrupt. The accumulator and data-pointer values come in as inputs.

Top module: `xfer_nextpc`

## Requirements
- R1: After reset, `pc_o` is 0x0000, `sp_o` is 0x07 and `in_isr_o` is 0.
- R2: Opcode 0x00, and any opcode that none of the encodings below match, is one byte long. It advances the PC by one and leaves the stack pointer unchanged.
- R3: Opcode 0x80 is followed by one signed offset byte. The new PC is the address after the offset byte plus the sign-extended offset, so both forward and backward targets are reached.
- R4: Opcode 0x02 is followed by the target's high byte and then its low byte. The new PC is that 16-bit value.
- R5: An opcode with bits 4:0 equal to 00001 is a page jump. It is followed by one byte. The new PC is bits 15:11 of the address after the second byte, then opcode bits 7:5, then the second byte. At a 2K block edge, the block of the following instruction is the one kept.
- R6: Opcode 0x73 is one byte long. It sets the PC to `dptr_i` plus the zero-extended `acc_i`, wrapping modulo 65536.
- R7: Opcode 0x12 is a long call, with operands laid out as in R4. An opcode with bits 4:0 equal to 10001 is a page call, with its target formed as in R5. Both kinds of call jump to the target and push the address after the call. The low byte goes to stack address sp+1 and the high byte to sp+2, and the stack pointer rises by 2.
- R8: Opcode 0x22 is one byte long. It sets the PC to {byte at sp, byte at sp-1}, lowers the stack pointer by 2 and does not change the interrupt flag.
- R9: Opcode 0x32 acts like R8 and also clears the interrupt-in-progress flag. With the flag already clear, its result equals that of R8.
- R10: A high `irq_enter_i` sets the flag on the next edge. When it falls in the same cycle as the last byte of opcode 0x32, the return still takes place and the flag ends up set.
- R11: In a cycle where `fetch_valid_i` is low, the PC, the stack pointer and any partly collected instruction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch byte present this cycle |
| fetch_byte_i | input | 8 | Instruction byte at address `pc_o` |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data-pointer value |
| irq_enter_i | input | 1 | Interrupt accepted; sets the flag |
| pc_o | output | 16 | Program counter, address of next byte |
| sp_o | output | 8 | Stack pointer |
| in_isr_o | output | 1 | Interrupt-in-progress flag |

## Verification
The interrupt flag has two drivers that can act in the same cycle: the external set and the clear done by return-from-interrupt. The bench raises `irq_enter_i` together with the final byte of a return-from-interrupt. It then expects the popped PC, the stack pointer lowered by 2, and the flag still set. A further case covers a return-from-interrupt with the flag already clear and expects plain-return results. Stalls are placed between the opcode and the operand bytes of a long jump to show that collection resumes correctly.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OPC_NOP   = 8'h00;
  localparam logic [7:0] OPC_LJMP  = 8'h02;
  localparam logic [7:0] OPC_LCALL = 8'h12;
  localparam logic [7:0] OPC_RET   = 8'h22;
  localparam logic [7:0] OPC_RETI  = 8'h32;
  localparam logic [7:0] OPC_IJMP  = 8'h73;
  localparam logic [7:0] OPC_SJMP  = 8'h80;
  localparam logic [4:0] PG_JMP_LO = 5'b00001;
  localparam logic [4:0] PG_CALL_LO = 5'b10001;

  typedef enum logic [3:0] {
    K_NOP, K_PJMP, K_PCALL, K_LJMP, K_LCALL, K_SJMP, K_IJMP, K_RET, K_RETI
  } kind_t;

  typedef enum logic [1:0] {
    PH_OP, PH_B1, PH_B2
  } phase_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [7:0] opcode_i,
  output kind_t      kind_o,
  output logic       one_byte_o
);
  always_comb begin
    if (opcode_i[4:0] == PG_JMP_LO) begin
      kind_o = K_PJMP;
    end else if (opcode_i[4:0] == PG_CALL_LO) begin
      kind_o = K_PCALL;
    end else begin
      unique case (opcode_i)
        OPC_LJMP:  kind_o = K_LJMP;
        OPC_LCALL: kind_o = K_LCALL;
        OPC_SJMP:  kind_o = K_SJMP;
        OPC_IJMP:  kind_o = K_IJMP;
        OPC_RET:   kind_o = K_RET;
        OPC_RETI:  kind_o = K_RETI;
        default:   kind_o = K_NOP;
      endcase
    end
  end

  always_comb begin
    unique case (kind_o)
      K_NOP, K_IJMP, K_RET, K_RETI: one_byte_o = 1'b1;
      default:                      one_byte_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int PAGE_W = 11
) (
  input  kind_t              kind_i,
  input  logic [ADDR_W-1:0]  seq_next_i,
  input  logic [2:0]         op_page_i,
  input  logic [7:0]         hi_byte_i,
  input  logic [7:0]         cur_byte_i,
  input  logic [7:0]         acc_i,
  input  logic [ADDR_W-1:0]  dptr_i,
  input  logic [ADDR_W-1:0]  ret_addr_i,
  output logic [ADDR_W-1:0]  target_o
);
  localparam int KEEP_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] page_tgt;
  logic [ADDR_W-1:0] idx_tgt;

  assign rel_ext  = {{(ADDR_W-8){cur_byte_i[7]}}, cur_byte_i};
  assign page_tgt = {seq_next_i[ADDR_W-1 -: KEEP_W], op_page_i, cur_byte_i};
  assign idx_tgt  = dptr_i + {{(ADDR_W-8){1'b0}}, acc_i};

  always_comb begin
    unique case (kind_i)
      K_SJMP:          target_o = seq_next_i + rel_ext;
      K_PJMP, K_PCALL: target_o = page_tgt;
      K_LJMP, K_LCALL: target_o = {hi_byte_i, cur_byte_i};
      K_IJMP:          target_o = idx_tgt;
      K_RET, K_RETI:   target_o = ret_addr_i;
      default:         target_o = seq_next_i;
    endcase
  end
endmodule

// File: rtl/xfer_stack.sv
module xfer_stack #(
  parameter int         DEPTH   = 16,
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic [15:0] push_addr_i,
  output logic [15:0] pop_addr_o,
  output logic [7:0]  sp_o
);
  localparam int IW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [7:0] sp_q, sp_d;
  logic [7:0] sp_p1, sp_p2, sp_m1;

  assign sp_p1 = sp_q + 8'd1;
  assign sp_p2 = sp_q + 8'd2;
  assign sp_m1 = sp_q - 8'd1;

  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_p2;
    else if (pop_i) sp_d = sp_q - 8'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sp_q <= SP_INIT;
    else if (push_i || pop_i)   sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[sp_p1[IW-1:0]] <= push_addr_i[7:0];
      mem[sp_p2[IW-1:0]] <= push_addr_i[15:8];
    end
  end

  assign pop_addr_o = {mem[sp_q[IW-1:0]], mem[sp_m1[IW-1:0]]};
  assign sp_o       = sp_q;

  // R7: a call raises the pointer by two
  p_push_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> sp_q == $past(sp_q) + 8'd2);
  // R8: a return lowers the pointer by two
  p_pop_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> sp_q == $past(sp_q) - 8'd2);
  // R8: the pushed address is what a return would read back next
  p_push_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> pop_addr_o == $past(push_addr_i));
  // R11: no access, pointer holds
  p_idle_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i || pop_i) |=> $stable(sp_q));
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/xfer_nextpc.sv
module xfer_nextpc
  import xfer_pkg::*;
#(
  parameter int         STACK_DEPTH = 16,
  parameter logic [7:0] SP_INIT     = 8'h07,
  parameter int         PAGE_W      = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid_i,
  input  logic [7:0]  fetch_byte_i,
  input  logic [7:0]  acc_i,
  input  logic [15:0] dptr_i,
  input  logic        irq_enter_i,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o,
  output logic        in_isr_o
);
  phase_t            ph_q, ph_d;
  kind_t             kind_q, kind_d;
  logic [7:0]        op_q, op_d;
  logic [7:0]        hi_q, hi_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              isr_q, isr_d;

  kind_t             dec_kind;
  logic              dec_one;
  kind_t             cur_kind;
  logic              done;
  logic              push, pop;
  logic [ADDR_W-1:0] seq_next;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] ret_addr;

  xfer_decode u_dec (
    .opcode_i  (fetch_byte_i),
    .kind_o    (dec_kind),
    .one_byte_o(dec_one)
  );

  assign seq_next = pc_q + 16'd1;
  assign cur_kind = (ph_q == PH_OP) ? dec_kind : kind_q;

  always_comb begin
    done = 1'b0;
    if (fetch_valid_i) begin
      unique case (ph_q)
        PH_OP:   done = dec_one;
        PH_B1:   done = (kind_q == K_PJMP) || (kind_q == K_PCALL) || (kind_q == K_SJMP);
        default: done = 1'b1;
      endcase
    end
  end

  assign push = done && ((cur_kind == K_LCALL) || (cur_kind == K_PCALL));
  assign pop  = done && ((cur_kind == K_RET) || (cur_kind == K_RETI));

  xfer_target #(.PAGE_W(PAGE_W)) u_tgt (
    .kind_i    (cur_kind),
    .seq_next_i(seq_next),
    .op_page_i (op_q[7:5]),
    .hi_byte_i (hi_q),
    .cur_byte_i(fetch_byte_i),
    .acc_i     (acc_i),
    .dptr_i    (dptr_i),
    .ret_addr_i(ret_addr),
    .target_o  (target)
  );

  xfer_stack #(.DEPTH(STACK_DEPTH), .SP_INIT(SP_INIT)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .pop_i      (pop),
    .push_addr_i(seq_next),
    .pop_addr_o (ret_addr),
    .sp_o       (sp_o)
  );

  // next-state
  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    op_d   = op_q;
    hi_d   = hi_q;
    pc_d   = pc_q;
    if (fetch_valid_i) begin
      pc_d = done ? target : seq_next;
      unique case (ph_q)
        PH_OP: begin
          if (!dec_one) begin
            ph_d   = PH_B1;
            kind_d = dec_kind;
            op_d   = fetch_byte_i;
          end
        end
        PH_B1: begin
          if (done) begin
            ph_d = PH_OP;
          end else begin
            ph_d = PH_B2;
            hi_d = fetch_byte_i;
          end
        end
        default: ph_d = PH_OP;
      endcase
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (irq_enter_i)                   isr_d = 1'b1;
    else if (pop && cur_kind == K_RETI) isr_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OP;
      kind_q <= K_NOP;
      op_q   <= 8'h00;
      hi_q   <= 8'h00;
      pc_q   <= '0;
    end else if (fetch_valid_i) begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      op_q   <= op_d;
      hi_q   <= hi_d;
      pc_q   <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= 1'b0;
    else        isr_q <= isr_d;
  end

  assign pc_o     = pc_q;
  assign in_isr_o = isr_q;

  // R11: stall keeps the PC
  p_stall_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_i |=> $stable(pc_q));
  // R2: a finished one-byte filler moves the PC by one
  p_nop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_kind == K_NOP) |=> pc_q == $past(pc_q) + 16'd1);
  // R5: a page jump stays in the block of the following instruction
  p_page_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_kind == K_PJMP) |=> pc_q[15:11] == $past(seq_next[15:11]));
  // R9: return-from-interrupt alone clears the flag
  p_reti_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cur_kind == K_RETI && !irq_enter_i) |=> !isr_q);
  // R10: entering an interrupt always leaves the flag set
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter_i |=> isr_q);
endmodule

// File: tb/xfer_nextpc_tb.sv
module xfer_nextpc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        fetch_valid_i;
  logic [7:0]  fetch_byte_i, acc_i;
  logic [15:0] dptr_i;
  logic        irq_enter_i;
  logic [15:0] pc_o;
  logic [7:0]  sp_o;
  logic        in_isr_o;

  xfer_nextpc u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i), .fetch_byte_i(fetch_byte_i),
    .acc_i(acc_i), .dptr_i(dptr_i), .irq_enter_i(irq_enter_i),
    .pc_o(pc_o), .sp_o(sp_o), .in_isr_o(in_isr_o)
  );

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        f;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_run = 0;

  // reference state
  logic [15:0] mpc;
  logic [7:0]  msp;
  logic        mflag;
  logic [7:0]  mstk [256];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_now(input string tag);
    exp_t e;
    e.pc = mpc; e.sp = msp; e.f = mflag; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pc_o !== e.pc || sp_o !== e.sp || in_isr_o !== e.f) begin
        errors++;
        $display("FAIL %s: pc=%h sp=%h isr=%b expected pc=%h sp=%h isr=%b",
                 e.tag, pc_o, sp_o, in_isr_o, e.pc, e.sp, e.f);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // reference update from the requirement encodings
  task automatic model(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input bit irq);
    logic [15:0] nx;
    bit reti;
    reti = 0;
    if (b0[4:0] == 5'b00001 || b0[4:0] == 5'b10001) begin
      nx = mpc + 16'd2;
      if (b0[4]) begin mstk[msp+8'd1] = nx[7:0]; mstk[msp+8'd2] = nx[15:8]; msp = msp + 8'd2; end
      mpc = {nx[15:11], b0[7:5], b1};
    end else if (b0 == 8'h02 || b0 == 8'h12) begin
      nx = mpc + 16'd3;
      if (b0 == 8'h12) begin mstk[msp+8'd1] = nx[7:0]; mstk[msp+8'd2] = nx[15:8]; msp = msp + 8'd2; end
      mpc = {b1, b2};
    end else if (b0 == 8'h80) begin
      mpc = mpc + 16'd2 + {{8{b1[7]}}, b1};
    end else if (b0 == 8'h73) begin
      mpc = dptr_i + {8'h00, acc_i};
    end else if (b0 == 8'h22 || b0 == 8'h32) begin
      mpc = {mstk[msp], mstk[msp-8'd1]};
      msp = msp - 8'd2;
      reti = (b0 == 8'h32);
    end else begin
      mpc = mpc + 16'd1;
    end
    if (irq) mflag = 1'b1;
    else if (reti) mflag = 1'b0;
  endtask

  function automatic int ilen(input logic [7:0] b0);
    if (b0[4:0] == 5'b00001 || b0[4:0] == 5'b10001 || b0 == 8'h80) return 2;
    if (b0 == 8'h02 || b0 == 8'h12) return 3;
    return 1;
  endfunction

  // driver: feeds one instruction, optionally stalling after the opcode
  task automatic run(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                     input int stall, input bit irq_last, input string tag);
    logic [7:0] bytes [3];
    int n;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    n = ilen(b0);
    model(b0, b1, b2, irq_last);
    for (int i = 0; i < n; i++) begin
      fetch_valid_i = 1'b1;
      fetch_byte_i  = bytes[i];
      irq_enter_i   = irq_last && (i == n-1);
      @(posedge clk); #1;
      fetch_valid_i = 1'b0;
      irq_enter_i   = 1'b0;
      fetch_byte_i  = 8'hEE;
      if (i == 0) begin
        for (int s = 0; s < stall; s++) begin @(posedge clk); #1; end
      end
    end
    expect_now(tag);
  endtask

  task automatic idle(input int n, input string tag);
    fetch_valid_i = 1'b0;
    fetch_byte_i  = 8'h02;
    for (int s = 0; s < n; s++) begin @(posedge clk); #1; end
    expect_now(tag);
  endtask

  task automatic pulse_irq(input string tag);
    irq_enter_i = 1'b1;
    @(posedge clk); #1;
    irq_enter_i = 1'b0;
    mflag = 1'b1;
    expect_now(tag);
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid_i = 1'b0; fetch_byte_i = 8'h00;
    acc_i = 8'h00; dptr_i = 16'h0000; irq_enter_i = 1'b0;
    mpc = 16'h0000; msp = 8'h07; mflag = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_now("R1 reset");
    @(posedge clk); #1;

    run(8'h00, 8'h00, 8'h00, 0, 0, "R2 nop");
    run(8'hA5, 8'h00, 8'h00, 0, 0, "R2 unrecognised");
    run(8'h80, 8'h10, 8'h00, 0, 0, "R3 short forward");
    run(8'h80, 8'hFE, 8'h00, 0, 0, "R3 short backward");
    run(8'h02, 8'h12, 8'h34, 2, 0, "R4 long jump with stall R11");
    run(8'hA1, 8'h56, 8'h00, 0, 0, "R5 page jump");
    run(8'h02, 8'h17, 8'hFE, 0, 0, "R4 long jump to block edge");
    run(8'h01, 8'h00, 8'h00, 0, 0, "R5 page jump at block edge");
    acc_i = 8'h20; dptr_i = 16'hFFF0;
    run(8'h73, 8'h00, 8'h00, 0, 0, "R6 indexed wrap");
    acc_i = 8'h05; dptr_i = 16'h0100;
    run(8'h73, 8'h00, 8'h00, 0, 0, "R6 indexed");
    run(8'h12, 8'h20, 8'h00, 0, 0, "R7 long call");
    run(8'h71, 8'h40, 8'h00, 0, 0, "R7 page call");
    run(8'h22, 8'h00, 8'h00, 0, 0, "R8 return");
    idle(4, "R11 idle");
    pulse_irq("R10 set flag");
    run(8'h32, 8'h00, 8'h00, 0, 0, "R9 reti clears");
    run(8'h12, 8'h30, 8'h00, 0, 0, "R7 long call again");
    run(8'h32, 8'h00, 8'h00, 0, 0, "R9 reti flag already clear");
    pulse_irq("R10 set flag again");
    run(8'h11, 8'h80, 8'h00, 0, 0, "R7 page call in block 0");
    run(8'h32, 8'h00, 8'h00, 0, 1, "R10 reti with same-cycle set");
    run(8'h12, 8'h45, 8'h67, 0, 0, "R7 call while flagged");
    run(8'h22, 8'h00, 8'h00, 0, 0, "R8 return keeps flag");

    @(posedge clk); #1;
    @(posedge clk); #1;
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule